// File: doc/BRIEF.md
# Hash Message Padding Unit

This block sits in front of a hash compression core and turns a message of arbitrary bit length into a stream of 512-bit padded blocks. The message enters as full-width chunks. Each chunk has a valid/ready handshake and a last flag. The final chunk also carries a count of how many of its bits belong to the message. Every chunk that is not final is forwarded unchanged. The final chunk is closed in three steps. A single one bit goes directly after the last message bit. Zero bits follow it. The last 128 bits of the block then hold the total message length in bits.

Bit 0 of every block is the earliest message bit, and the numbering rises toward the end of the block. The length field holds its most significant bit at position 384 and its least significant bit at position 511. So 384 bits of a closing block remain for data and the marker. When the final chunk holds 384 bits or more, that chunk is sent with only the marker and zero fill. A second block, made of zeros and the length field, follows it. While that second block is waiting, the input is stalled. Every output block is held stable until the consumer accepts it.

Top module: `hash_pad_unit`

## Requirements
- R1: A chunk accepted with in_last low appears unchanged on out_data, with out_last low.
- R2: A final chunk whose in_bits count n is at most 383 produces one block, flagged out_last. Bits below n are the message bits. Bit n is 1. The bits between n and 384 are 0. Bits 384..511 hold the message length, MSB at bit 384.
- R3: A final chunk whose n lies in 384..511 produces two blocks. The first block holds the message bits, a 1 at bit n and zeros above it, and has out_last low. The second block has zeros in bits 0..383, the length field in bits 384..511, and out_last high.
- R4: Bits of the final chunk at or above its count n are output as zero, whatever value they have at the input.
- R5: The length field equals 512 times the number of non-final chunks of the message, plus n of the final chunk.
- R6: A final chunk with n = 0 produces a block with bit 0 set, zeros up to bit 383, and the length field. This covers an empty message and a message that is a multiple of 512 bits long.
- R7: in_ready is low from the cycle the first block of a two-block close is loaded until the second block is loaded.
- R8: While out_valid is high and out_ready is low, out_data, out_last and out_valid hold their values.
- R9: A synchronous reset clears out_valid, raises in_ready and discards the partly counted length, so the next message is counted from zero.
- R10: After a message closes, the length count restarts at zero for the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input chunk present |
| in_ready | output | 1 | Block can take a chunk |
| in_data | input | 512 | Message chunk, bit 0 earliest |
| in_last | input | 1 | Chunk is the final one of the message |
| in_bits | input | 9 | Message bits in the final chunk (0..511) |
| out_valid | output | 1 | Output block present |
| out_ready | input | 1 | Consumer takes the block |
| out_data | output | 512 | Padded block, bit 0 earliest |
| out_last | output | 1 | Block closes the message |

## Verification
The bench builds the block with its default widths: 512-bit blocks, a 128-bit length field and a 9-bit count. These are the sizes at which the spill threshold sits at 384. With them the bench can drive the counts on each side of that threshold (383 and 384), the highest count (511) and the zero count. The widths also let length values cover messages of several chunks. Every edge of the one-block and two-block closes is therefore driven at the real sizes, not at scaled-down ones.

// File: rtl/hash_pad_pkg.sv
package hash_pad_pkg;

  typedef enum logic [1:0] {
    BK_BODY  = 2'd0,
    BK_CLOSE = 2'd1,
    BK_SPILL = 2'd2,
    BK_TAIL  = 2'd3
  } blk_kind_t;

endpackage

// File: rtl/hash_pad_len_acc.sv
module hash_pad_len_acc #(
  parameter int BLK_W = 512,
  parameter int LEN_W = 128,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_full,
  input  logic             add_last,
  input  logic [CNT_W-1:0] last_bits,
  output logic [LEN_W-1:0] len_now,
  output logic [LEN_W-1:0] len_hold
);

  localparam logic [LEN_W-1:0] FULL_STEP = LEN_W'(BLK_W);

  logic [LEN_W-1:0] acc_q;

  function automatic logic [LEN_W-1:0] close_len(input logic [LEN_W-1:0] base,
                                                  input logic [CNT_W-1:0] n);
    return base + LEN_W'(n);
  endfunction

  assign len_now = close_len(acc_q, last_bits);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      len_hold <= '0;
    end else if (add_last) begin
      len_hold <= len_now;
      acc_q    <= '0;
    end else if (add_full) begin
      acc_q <= acc_q + FULL_STEP;
    end
  end

endmodule

// File: rtl/hash_pad_fmt.sv
module hash_pad_fmt
  import hash_pad_pkg::*;
#(
  parameter int BLK_W = 512,
  parameter int LEN_W = 128,
  parameter int CNT_W = 9
) (
  input  blk_kind_t        kind,
  input  logic [BLK_W-1:0] data,
  input  logic [CNT_W-1:0] bits,
  input  logic [LEN_W-1:0] len,
  output logic [BLK_W-1:0] blk
);

  localparam int FREE_W = BLK_W - LEN_W;

  logic [BLK_W-1:0] len_field;
  logic [BLK_W-1:0] marked;

  // length sits MSB-first at the top of the block
  assign len_field[FREE_W-1:0] = '0;
  for (genvar j = 0; j < LEN_W; j++) begin : g_len
    assign len_field[BLK_W-1-j] = len[j];
  end

  function automatic logic [BLK_W-1:0] keep_low(input logic [BLK_W-1:0] d,
                                                 input logic [CNT_W-1:0] n);
    logic [BLK_W-1:0] r;
    for (int i = 0; i < BLK_W; i++) begin
      r[i] = (i < int'(n)) ? d[i] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [BLK_W-1:0] add_marker(input logic [BLK_W-1:0] d,
                                                   input logic [CNT_W-1:0] n);
    logic [BLK_W-1:0] r;
    r    = d;
    r[n] = 1'b1;
    return r;
  endfunction

  assign marked = add_marker(keep_low(data, bits), bits);

  always_comb begin
    unique case (kind)
      BK_BODY:  blk = data;
      BK_CLOSE: blk = marked | len_field;
      BK_SPILL: blk = marked;
      default:  blk = len_field;
    endcase
  end

endmodule

// File: rtl/hash_pad_out_reg.sv
module hash_pad_out_reg #(
  parameter int BLK_W = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BLK_W-1:0] nxt_data,
  input  logic             nxt_last,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_data,
  output logic             out_last
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= nxt_data;
      out_last  <= nxt_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/hash_pad_unit.sv
module hash_pad_unit
  import hash_pad_pkg::*;
#(
  parameter int BLK_W = 512,
  parameter int LEN_W = 128,
  parameter int CNT_W = $clog2(BLK_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_data,
  input  logic             in_last,
  input  logic [CNT_W-1:0] in_bits,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BLK_W-1:0] out_data,
  output logic             out_last
);

  localparam logic [CNT_W-1:0] SPILL_AT = CNT_W'(BLK_W - LEN_W);

  logic             slot_free;
  logic             take;
  logic             take_body;
  logic             take_fit;
  logic             take_spill;
  logic             tail_go;
  logic             load;
  logic             spill_pend;
  blk_kind_t        kind;
  logic [LEN_W-1:0] len_now;
  logic [LEN_W-1:0] len_hold;
  logic [LEN_W-1:0] len_sel;
  logic [BLK_W-1:0] nxt_blk;
  logic             nxt_last;

  assign slot_free  = !out_valid || out_ready;
  assign in_ready   = slot_free && !spill_pend;
  assign take       = in_valid && in_ready;
  assign take_body  = take && !in_last;
  assign take_fit   = take && in_last && (in_bits < SPILL_AT);
  assign take_spill = take && in_last && !(in_bits < SPILL_AT);
  assign tail_go    = spill_pend && slot_free;
  assign load       = take || tail_go;

  always_comb begin
    if (tail_go)        kind = BK_TAIL;
    else if (take_body) kind = BK_BODY;
    else if (take_fit)  kind = BK_CLOSE;
    else                kind = BK_SPILL;
  end

  assign nxt_last = (kind == BK_CLOSE) || (kind == BK_TAIL);
  assign len_sel  = spill_pend ? len_hold : len_now;

  always_ff @(posedge clk) begin
    if (rst)             spill_pend <= 1'b0;
    else if (take_spill) spill_pend <= 1'b1;
    else if (tail_go)    spill_pend <= 1'b0;
  end

  hash_pad_len_acc #(.BLK_W(BLK_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) len_i (
    .clk(clk), .rst(rst), .add_full(take_body), .add_last(take && in_last),
    .last_bits(in_bits), .len_now(len_now), .len_hold(len_hold)
  );

  hash_pad_fmt #(.BLK_W(BLK_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) fmt_i (
    .kind(kind), .data(in_data), .bits(in_bits), .len(len_sel), .blk(nxt_blk)
  );

  hash_pad_out_reg #(.BLK_W(BLK_W)) out_i (
    .clk(clk), .rst(rst), .load(load), .nxt_data(nxt_blk), .nxt_last(nxt_last),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last)
  );

endmodule

// File: rtl/hash_pad_chk.sv
module hash_pad_chk #(
  parameter int BLK_W = 512,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic [BLK_W-1:0] in_data,
  input logic [CNT_W-1:0] in_bits,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BLK_W-1:0] out_data,
  input logic             out_last,
  input logic             take_body,
  input logic             take_fit,
  input logic             take_spill,
  input logic             spill_pend
);

  logic [CNT_W-1:0] bits_q;
  always_ff @(posedge clk) bits_q <= in_bits;

  // R1
  body_pass_chk: assert property (@(posedge clk) disable iff (rst)
    take_body |=> out_valid && !out_last && out_data == $past(in_data));

  // R2
  fit_close_chk: assert property (@(posedge clk) disable iff (rst)
    take_fit |=> out_valid && out_last && out_data[bits_q]);

  // R3
  spill_first_chk: assert property (@(posedge clk) disable iff (rst)
    take_spill |=> out_valid && !out_last && out_data[bits_q] && spill_pend);

  // R3
  tail_last_chk: assert property (@(posedge clk) disable iff (rst)
    spill_pend && out_valid && out_ready |=> out_valid && out_last);

  // R7
  pend_stall_chk: assert property (@(posedge clk) disable iff (rst)
    spill_pend |-> !in_ready);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

endmodule

bind hash_pad_unit hash_pad_chk #(.BLK_W(BLK_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .in_ready(in_ready), .in_data(in_data), .in_bits(in_bits),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .take_body(take_body), .take_fit(take_fit),
  .take_spill(take_spill), .spill_pend(spill_pend)
);

// File: tb/hash_pad_unit_tb_top.sv
module hash_pad_unit_tb_top;

  localparam int BW = 512;
  localparam int LW = 128;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [BW-1:0] in_data = '0;
  logic          in_last = 1'b0;
  logic [CW-1:0] in_bits = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [BW-1:0] out_data;
  logic          out_last;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  hash_pad_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_bits(in_bits),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  function automatic logic [BW-1:0] rnd_blk();
    logic [BW-1:0] r;
    for (int k = 0; k < BW / 32; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  // closing block built bit by bit from the requirement text
  function automatic logic [BW-1:0] exp_close(input logic [BW-1:0] d, input int n,
                                              input logic [LW-1:0] len, input bit with_len);
    logic [BW-1:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = d[i];
    r[n] = 1'b1;
    if (with_len)
      for (int j = 0; j < LW; j++) r[BW-1-j] = len[j];
    return r;
  endfunction

  function automatic logic [BW-1:0] exp_tail(input logic [LW-1:0] len);
    logic [BW-1:0] r = '0;
    for (int j = 0; j < LW; j++) r[BW-1-j] = len[j];
    return r;
  endfunction

  task automatic check(input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [BW-1:0] d, input bit last, input int n);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last; in_bits = CW'(n);
    @(negedge clk);
    in_valid = 1'b0; in_data = rnd_blk(); in_last = 1'b0; in_bits = '0;
  endtask

  // called at a negedge; checks the visible block and lets it be taken
  task automatic get(input string req, input logic [BW-1:0] exp, input bit exp_last);
    while (!out_valid) @(negedge clk);
    check(req, out_data, exp);
    check(req, BW'(out_last), BW'(exp_last));
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R9 out_valid", BW'(out_valid), '0);
    check("R9 in_ready", BW'(in_ready), BW'(1));
  endtask

  task automatic t_short();
    logic [BW-1:0] d = '0;
    d[7:0] = 8'b0011_0011; // first bits in order 1,1,0,0,1,1,0,0
    send(d, 1'b1, 8);
    get("R2 eight-bit message", exp_close(d, 8, LW'(8), 1'b1), 1'b1);
  endtask

  task automatic t_garbage();
    logic [BW-1:0] d = rnd_blk();
    d[BW-1:200] = '1;
    send(d, 1'b1, 100);
    get("R4 junk above count", exp_close(d, 100, LW'(100), 1'b1), 1'b1);
  endtask

  task automatic t_multi();
    logic [BW-1:0] a = rnd_blk();
    logic [BW-1:0] b = rnd_blk();
    logic [BW-1:0] c = rnd_blk();
    send(a, 1'b0, 0); get("R1 chunk one", a, 1'b0);
    send(b, 1'b0, 0); get("R1 chunk two", b, 1'b0);
    send(c, 1'b1, 20);
    get("R5 length 1044", exp_close(c, 20, LW'(1044), 1'b1), 1'b1);
  endtask

  task automatic t_edge383();
    logic [BW-1:0] d = rnd_blk();
    send(d, 1'b1, 383);
    get("R2 count 383", exp_close(d, 383, LW'(383), 1'b1), 1'b1);
  endtask

  task automatic t_spill(input int n);
    logic [BW-1:0] d = rnd_blk();
    send(d, 1'b1, n);
    check("R7 in_ready low while pending", BW'(in_ready), '0);
    get("R3 spill first", exp_close(d, n, '0, 1'b0), 1'b0);
    get("R3 spill tail", exp_tail(LW'(n)), 1'b1);
    check("R7 in_ready back", BW'(in_ready), BW'(1));
  endtask

  task automatic t_empty();
    send(rnd_blk(), 1'b1, 0);
    get("R6 empty message", exp_close('0, 0, '0, 1'b1), 1'b1);
    begin
      logic [BW-1:0] a = rnd_blk();
      send(a, 1'b0, 0); get("R1 whole chunk", a, 1'b0);
      send(rnd_blk(), 1'b1, 0);
      get("R6 multiple of 512", exp_close('0, 0, LW'(512), 1'b1), 1'b1);
    end
  endtask

  task automatic t_stall();
    logic [BW-1:0] d = rnd_blk();
    logic [BW-1:0] seen;
    out_ready = 1'b0;
    send(d, 1'b1, 450);
    seen = out_data;
    repeat (3) @(negedge clk);
    check("R8 valid held", BW'(out_valid), BW'(1));
    check("R8 data held", out_data, seen);
    check("R7 in_ready low in stall", BW'(in_ready), '0);
    out_ready = 1'b1;
    get("R3 stalled spill first", exp_close(d, 450, '0, 1'b0), 1'b0);
    out_ready = 1'b0;
    @(negedge clk);
    check("R8 tail held", out_data, exp_tail(LW'(450)));
    check("R7 in_ready low with tail waiting", BW'(in_ready), '0);
    out_ready = 1'b1;
    get("R3 stalled spill tail", exp_tail(LW'(450)), 1'b1);
  endtask

  task automatic t_restart();
    logic [BW-1:0] d = rnd_blk();
    send(rnd_blk(), 1'b0, 0);
    do_reset();
    @(negedge clk);
    check("R9 cleared by reset", BW'(out_valid), '0);
    send(d, 1'b1, 8);
    get("R9 count after reset", exp_close(d, 8, LW'(8), 1'b1), 1'b1);
    send(d, 1'b1, 30);
    get("R10 next message restarts", exp_close(d, 30, LW'(30), 1'b1), 1'b1);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_short();
    t_garbage();
    t_multi();
    t_edge383();
    t_spill(384);
    t_spill(511);
    t_empty();
    t_stall();
    t_restart();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule